// File: doc/BRIEF.md
# Single-Port RAM Bubble Sort Engine

This block sorts a small table of unsigned words that lives in a single-port synchronous RAM. After a start pulse it works in three steps. First it reads every word of the RAM into a local register array. Next it bubble-sorts that array in place, testing one adjacent pair per clock. Last it writes the sorted words back over the same RAM addresses. The RAM has one port, so reading and writing happen in separate phases. The one-cycle read latency is absorbed by capturing each word one cycle after its address is presented.

The controller has five states. IDLE waits for start after reset. IDLE goes to LOAD on start. LOAD presents addresses 0 to N-1 and captures the returned data, and goes to SORT after the final capture. SORT scans pairs 0..N-2 once per pass. It goes to STORE at the end of a pass that made no swap, or at the end of pass N-1. STORE writes addresses 0..N-1 and goes to DONE after the last write. DONE raises the done flag and leaves the RAM alone. It goes back to LOAD on the next start. A synchronous reset returns the controller to IDLE from any state.

Default sizing is 16 words of 8 bits.

Top module: `mem_bubble_sorter`

## Requirements
- R1: A synchronous reset, asserted in any state, leaves done low, ram_en low, ram_we low and ram_addr at 0 from the next cycle. These hold until a start pulse arrives.
- R2: After start, the load phase reads addresses 0 to 15 in ascending order with ram_en high and ram_we low, exactly one read per address. Each word is captured one cycle after its address is presented, so the load phase lasts 17 cycles.
- R3: After the run, RAM address 0 holds the smallest value and the contents are in ascending order. Values are compared as unsigned 8-bit numbers.
- R4: The written-back contents are a permutation of the original contents: duplicates are kept, and equal values are never swapped.
- R5: In the write phase, ram_we is high for exactly 16 cycles, on addresses 0 to 15 in order. Each cycle's ram_wdata is the sorted word for that address.
- R6: done rises in the cycle after the last write and stays high until the next start or reset. While done is high, ram_en and ram_we stay low.
- R7: A start pulse that arrives while the engine is in LOAD, SORT or STORE has no effect on the result or on the run length.
- R8: Each sort pass takes 15 cycles. Sorting ends after the first pass that makes no swap, so already-sorted data takes 1 pass. From the start edge, done is seen after 33 + 15*P clock edges, where P is the number of passes.
- R9: Sorting stops after at most 15 passes, so reverse-sorted data finishes in exactly 15 passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the engine and the RAM |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins a run from IDLE or DONE |
| done | output | 1 | High once the sorted data has been written back |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 4 | RAM address |
| ram_wdata | output | 8 | Data written to the RAM |
| ram_rdata | input | 8 | RAM read data, valid one cycle after an enabled read |

## Verification
The assertions assume a few things about the environment:
- The RAM returns the word at the presented address exactly one cycle after an enabled read.
- Nothing other than the engine writes the RAM during a run.
- start is sampled only on clock edges.

The bench follows these assumptions in three ways. Its behavioural RAM is read-first with a registered output. Preloading happens only while the engine is in IDLE or DONE. All inputs are driven on the falling edge. Extra start pulses are injected on purpose inside LOAD and SORT so that the ignore rule is exercised within these limits.

// File: rtl/bsort_pkg.sv
package bsort_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_SORT  = 3'd2,
        ST_STORE = 3'd3,
        ST_DONE  = 3'd4
    } phase_e;
endpackage

// File: rtl/sort_regfile.sv
module sort_regfile #(
    parameter int N_WORDS = 16,
    parameter int DATA_W  = 8,
    localparam int AW     = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [AW-1:0]     ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              cmp_en,
    input  logic [AW-1:0]     cmp_idx,
    output logic              cmp_gt,
    input  logic [AW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] arr [N_WORDS];
    logic [AW-1:0]     nxt_idx;
    logic [DATA_W-1:0] lo_val, hi_val;
    logic              do_swap;

    assign nxt_idx = cmp_idx + AW'(1);
    assign lo_val  = arr[cmp_idx];
    assign hi_val  = arr[nxt_idx];
    // strict greater-than: equal neighbours stay put
    assign cmp_gt  = lo_val > hi_val;
    assign do_swap = cmp_en && cmp_gt;
    assign rd_data = arr[rd_idx];

    for (genvar g = 0; g < N_WORDS; g++) begin : g_cell
        logic [DATA_W-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst)
                cell_q <= '0;
            else if (ld_en && ld_idx == AW'(g))
                cell_q <= ld_data;
            else if (do_swap && cmp_idx == AW'(g))
                cell_q <= hi_val;
            else if (do_swap && nxt_idx == AW'(g))
                cell_q <= lo_val;
        end
        assign arr[g] = cell_q;
    end

    // checker state: remember last compare and last load
    logic              chk_cmp_v, chk_ld_v;
    logic [AW-1:0]     chk_cmp_i, chk_cmp_n, chk_ld_i;
    logic [DATA_W-1:0] chk_ld_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_cmp_v <= 1'b0;
            chk_ld_v  <= 1'b0;
            chk_cmp_i <= '0;
            chk_ld_i  <= '0;
            chk_ld_d  <= '0;
        end else begin
            chk_cmp_v <= cmp_en;
            chk_cmp_i <= cmp_idx;
            chk_ld_v  <= ld_en;
            chk_ld_i  <= ld_idx;
            chk_ld_d  <= ld_data;
        end
    end
    assign chk_cmp_n = chk_cmp_i + AW'(1);

    // R3
    pair_order_chk: assert property (@(posedge clk) disable iff (rst)
        chk_cmp_v |-> (arr[chk_cmp_i] <= arr[chk_cmp_n]));

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        chk_ld_v |-> (arr[chk_ld_i] == chk_ld_d));
endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl
    import bsort_pkg::*;
#(
    parameter int N_WORDS = 16,
    localparam int AW     = $clog2(N_WORDS),
    localparam int CW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cmp_gt,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic          ld_en,
    output logic [AW-1:0] ld_idx,
    output logic          cmp_en,
    output logic [AW-1:0] cmp_idx,
    output logic [AW-1:0] rd_idx,
    output logic          done
);
    localparam logic [AW-1:0] LAST_PAIR = AW'(N_WORDS - 2);
    localparam logic [AW-1:0] LAST_PASS = AW'(N_WORDS - 2);
    localparam logic [CW-1:0] LOAD_END  = CW'(N_WORDS);
    localparam logic [CW-1:0] STORE_END = CW'(N_WORDS - 1);

    phase_e        state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] pair_q, pass_q;
    logic          swapped_q;
    logic          pass_end, pass_swapped;

    assign pass_end     = (pair_q == LAST_PAIR);
    assign pass_swapped = swapped_q || cmp_gt;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LOAD;
            ST_LOAD:  if (cnt_q == LOAD_END) state_d = ST_SORT;
            ST_SORT:  if (pass_end && (!pass_swapped || pass_q == LAST_PASS))
                          state_d = ST_STORE;
            ST_STORE: if (cnt_q == STORE_END) state_d = ST_DONE;
            ST_DONE:  if (start) state_d = ST_LOAD;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // counters
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            pair_q    <= '0;
            pass_q    <= '0;
            swapped_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_LOAD: cnt_q <= (state_d == ST_SORT) ? '0 : cnt_q + CW'(1);
                ST_SORT: begin
                    if (pass_end) begin
                        pair_q    <= '0;
                        pass_q    <= pass_q + AW'(1);
                        swapped_q <= 1'b0;
                    end else begin
                        pair_q    <= pair_q + AW'(1);
                        swapped_q <= pass_swapped;
                    end
                end
                ST_STORE: cnt_q <= cnt_q + CW'(1);
                default: begin
                    cnt_q     <= '0;
                    pair_q    <= '0;
                    pass_q    <= '0;
                    swapped_q <= 1'b0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        ram_en   = 1'b0;
        ram_we   = 1'b0;
        ram_addr = '0;
        ld_en    = 1'b0;
        ld_idx   = AW'(cnt_q - CW'(1));
        cmp_en   = 1'b0;
        cmp_idx  = pair_q;
        rd_idx   = cnt_q[AW-1:0];
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: begin
                ram_en   = (cnt_q < LOAD_END);
                ram_addr = cnt_q[AW-1:0];
                ld_en    = (cnt_q != '0);
            end
            ST_SORT:  cmp_en = 1'b1;
            ST_STORE: begin
                ram_en   = 1'b1;
                ram_we   = 1'b1;
                ram_addr = cnt_q[AW-1:0];
            end
            ST_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    // write counter for checking only
    logic [CW-1:0] wr_seen_q;
    always_ff @(posedge clk) begin
        if (rst || state_q == ST_IDLE || state_q == ST_DONE) wr_seen_q <= '0;
        else if (ram_we) wr_seen_q <= wr_seen_q + CW'(1);
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!done && !ram_en && !ram_we && ram_addr == '0));

    // R5
    we_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + AW'(1)));

    // R5
    write_total_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (wr_seen_q == CW'(N_WORDS)));

    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!ram_en && !ram_we));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && state_q != ST_DONE) |=> (state_q != ST_IDLE));

    // R9
    pass_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SORT) |-> (pass_q <= LAST_PASS));
endmodule

// File: rtl/mem_bubble_sorter.sv
module mem_bubble_sorter #(
    parameter int N_WORDS = 16,
    parameter int DATA_W  = 8,
    localparam int AW     = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              done,
    output logic              ram_en,
    output logic              ram_we,
    output logic [AW-1:0]     ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    logic          ld_en, cmp_en, cmp_gt;
    logic [AW-1:0] ld_idx, cmp_idx, rd_idx;

    sort_ctrl #(.N_WORDS(N_WORDS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmp_gt   (cmp_gt),
        .ram_en   (ram_en),
        .ram_we   (ram_we),
        .ram_addr (ram_addr),
        .ld_en    (ld_en),
        .ld_idx   (ld_idx),
        .cmp_en   (cmp_en),
        .cmp_idx  (cmp_idx),
        .rd_idx   (rd_idx),
        .done     (done)
    );

    sort_regfile #(.N_WORDS(N_WORDS), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ram_rdata),
        .cmp_en  (cmp_en),
        .cmp_idx (cmp_idx),
        .cmp_gt  (cmp_gt),
        .rd_idx  (rd_idx),
        .rd_data (ram_wdata)
    );
endmodule

// File: tb/mem_bubble_sorter_bench.sv
module mem_bubble_sorter_bench;
    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       done, ram_en, ram_we;
    logic [3:0] ram_addr;
    logic [7:0] ram_wdata, ram_rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem   [N];
    logic [7:0] stim  [N];
    logic [7:0] exp_a [N];
    int rd_cnt, wr_cnt, ord_err, quiet_err;

    always #10 clk = ~clk;

    mem_bubble_sorter u_mem_bubble_sorter (
        .clk(clk), .rst(rst), .start(start), .done(done),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // behavioural single-port RAM, read-first, registered output
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            ram_rdata <= mem[ram_addr];
        end
    end

    // port monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (ram_en && !ram_we) begin
                if (int'(ram_addr) != rd_cnt) ord_err++;
                rd_cnt++;
            end
            if (ram_we) begin
                if (wr_cnt >= N || int'(ram_addr) != wr_cnt || ram_wdata != exp_a[wr_cnt])
                    ord_err++;
                wr_cnt++;
            end
            if (done && ram_en) quiet_err++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference: unsigned ascending bubble sort with early exit and pass cap
    task automatic ref_sort(output int passes);
        logic [7:0] t;
        bit sw;
        for (int i = 0; i < N; i++) exp_a[i] = stim[i];
        passes = 0;
        do begin
            sw = 0;
            for (int i = 0; i < N - 1; i++) begin
                if (exp_a[i] > exp_a[i+1]) begin
                    t = exp_a[i]; exp_a[i] = exp_a[i+1]; exp_a[i+1] = t; sw = 1;
                end
            end
            passes++;
        end while (sw && passes < N - 1);
    endtask

    task automatic run_case(input string name, input bit extra_start);
        int p, n;
        int cnt_a [256];
        int cnt_b [256];
        bit ordered;
        for (int i = 0; i < N; i++) mem[i] = stim[i];
        ref_sort(p);
        rd_cnt = 0; wr_cnt = 0; ord_err = 0; quiet_err = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
            if (extra_start && (n == 5 || n == 20)) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        chk(n == 33 + 15 * p, "R8", {name, " cycles to done"}, n, 33 + 15 * p);
        if (p == N - 1) chk(n == 33 + 15 * (N - 1), "R9", {name, " capped run"}, n, 33 + 15 * (N - 1));
        if (extra_start) chk(n == 33 + 15 * p, "R7", {name, " run length with busy start"}, n, 33 + 15 * p);
        chk(rd_cnt == N, "R2", {name, " read count"}, rd_cnt, N);
        chk(wr_cnt == N, "R5", {name, " write count"}, wr_cnt, N);
        chk(ord_err == 0, "R5", {name, " address/data order errors"}, ord_err, 0);
        ordered = 1;
        for (int i = 0; i < N; i++) begin
            if (mem[i] != exp_a[i]) ordered = 0;
        end
        chk(ordered, "R3", {name, " ascending contents, addr0"}, int'(mem[0]), int'(exp_a[0]));
        for (int v = 0; v < 256; v++) begin cnt_a[v] = 0; cnt_b[v] = 0; end
        for (int i = 0; i < N; i++) begin cnt_a[stim[i]]++; cnt_b[mem[i]]++; end
        ordered = 1;
        for (int v = 0; v < 256; v++) if (cnt_a[v] != cnt_b[v]) ordered = 0;
        chk(ordered, "R4", {name, " permutation kept"}, int'(ordered), 1);
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R6", {name, " done held"}, int'(done), 1);
        chk(quiet_err == 0, "R6", {name, " RAM quiet while done"}, quiet_err, 0);
    endtask

    task automatic test_reset_mid_run();
        for (int i = 0; i < N; i++) stim[i] = 8'(N - i);
        for (int i = 0; i < N; i++) mem[i] = stim[i];
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (25) @(negedge clk);
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk(!done && !ram_en && !ram_we && ram_addr == 4'd0, "R1",
            "outputs after mid-run reset", {ram_en, ram_we, done}, 0);
        repeat (6) @(negedge clk);
        chk(!ram_en && !done, "R1", "idle without start", {ram_en, done}, 0);
        chk(mem[0] == 8'(N), "R1", "RAM untouched by aborted run", int'(mem[0]), N);
    endtask

    initial begin
        for (int i = 0; i < N; i++) mem[i] = 8'h00;
        ram_rdata = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !ram_en && !ram_we && ram_addr == 4'd0, "R1",
            "reset state", {ram_en, ram_we, done}, 0);

        for (int i = 0; i < N; i++) stim[i] = 8'(i * 7);
        run_case("sorted", 0);
        for (int i = 0; i < N; i++) stim[i] = 8'(255 - i * 11);
        run_case("reverse", 0);
        for (int i = 0; i < N; i++) stim[i] = 8'($urandom % 6);
        run_case("duplicates", 0);
        for (int i = 0; i < N; i++) stim[i] = 8'h55;
        run_case("all equal", 0);
        for (int i = 0; i < N; i++) stim[i] = (i % 2 == 0) ? 8'hFF : 8'h00;
        run_case("extremes", 0);
        for (int i = 0; i < N; i++) stim[i] = 8'($urandom);
        run_case("random busy start", 1);
        test_reset_mid_run();
        for (int i = 0; i < N; i++) stim[i] = 8'($urandom);
        run_case("random after reset", 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule